// File: doc/BRIEF.md
# Character Display Host Register File

This block is the storage and host-access front end of an eight-digit dot-matrix character display controller. A host writes to it over a byte-wide parallel bus using a chip enable and a write strobe. A flash-select line and two address bits steer each write into one of five storage areas:

- per-digit blink bits;
- a glyph-slot pointer;
- a user glyph pattern memory;
- per-digit character cells;
- a control word.

The block holds the stored contents and presents them to a separate refresh engine. That engine reads the character cells, the blink bits and the control word directly, and fetches glyph rows through a dedicated read port.

The host strobes are asynchronous to the display clock. The block synchronises them and turns each rising edge of the write strobe into a single internal write. A read-data output always shows the location that the current select and address inputs decode to. After reset, every digit holds the blank code and a ready output stays low for three display clocks. Writes that reach the storage while ready is low are discarded. The block also runs a free-running digit scan counter, which reset returns to zero.

Top module: `disp_host_regs`

## Requirements
- R1: With `flash_sel_n` low, a write stores `host_data[0]` as the blink bit of digit `host_addr[2:0]` (output `blink_bits`, bit i = digit i). `host_data[7:1]` and `host_addr[4:3]` have no effect.
- R2: With `flash_sel_n` high and `host_addr[4:3]` = 00, a write stores `host_data[3:0]` in the glyph-slot pointer `glyph_ptr`.
- R3: With `flash_sel_n` high and `host_addr[4:3]` = 01, a write stores `host_data[4:0]` in glyph memory entry {`glyph_ptr`, `host_addr[2:0]`}. The refresh port `pat_raddr` reads this entry back on `pat_rdata`.
- R4: With `flash_sel_n` high and `host_addr[4:3]` = 11, a write stores all eight data bits in the character cell of digit `host_addr[2:0]`, shown on `char_cells[8i+7:8i]`. Bit 7 is kept as stored: 0 marks a 7-bit character code and 1 marks a glyph slot number.
- R5: With `flash_sel_n` high and `host_addr[4:3]` = 10, a write stores all eight data bits in `ctrl_word`.
- R6: A write is taken only when `ce_n` is low while `wr_n` rises. Each rising edge of `wr_n` produces exactly one write, which is visible no later than five clocks after the edge.
- R7: While `rst_n` is low, every blink bit is 0, `ctrl_word` is 00h, every character cell is 20h, `scan_pos` is 0 and `ready` is 0.
- R8: `ready` rises on the third clock edge after `rst_n` is released and then stays high. A write that arrives while `ready` is low changes nothing.
- R9: `rd_data` shows the currently decoded location, with unused upper bits at zero: the blink bit in bit 0, the pointer in bits 3:0, the glyph row in bits 4:0, and the full byte for a character cell or the control word.
- R10: `scan_pos` advances by one on every clock edge and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_data | input | 8 | Host write data |
| host_addr | input | 5 | Host address; bits 2:0 give digit or row, bits 4:3 give the area |
| flash_sel_n | input | 1 | Low selects the blink bits |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| rd_data | output | 8 | Read-back of the decoded location |
| ready | output | 1 | High once the host may access the block |
| char_cells | output | 64 | Eight character cells, digit i at bits 8i+7:8i |
| blink_bits | output | 8 | Blink bit per digit |
| glyph_ptr | output | 4 | Glyph-slot pointer |
| ctrl_word | output | 8 | Control word |
| pat_raddr | input | 7 | Refresh read address into glyph memory |
| pat_rdata | output | 5 | Glyph row at `pat_raddr` |
| scan_pos | output | 3 | Free-running digit scan counter |

## Verification
On every cycle, the assertions check that the internal write pulse never lasts two cycles, and that `ready` never falls once it is up. They also check that no stored register moves while `ready` is low, that control-word, pointer and blink writes land the data seen one cycle earlier, and that the scan counter steps by one. The bench scenarios are needed to show the end-to-end decode from bus pins to each area. They also show that unused data and address bits are dropped, that a strobe with chip enable high is ignored, and that a write arriving before `ready` is lost. Finally, they show that a second reset restores the blank cells.

// File: rtl/disp_host_regs.sv
module disp_host_regs #(
  parameter int DIGITS       = 8,
  parameter int CELL_W       = 8,
  parameter int ROW_W        = 5,
  parameter int SLOT_W       = 4,
  parameter int READY_CYCLES = 3,
  parameter logic [7:0] BLANK = 8'h20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               host_data,
  input  logic [4:0]               host_addr,
  input  logic                     flash_sel_n,
  input  logic                     ce_n,
  input  logic                     wr_n,
  output logic [7:0]               rd_data,
  output logic                     ready,
  output logic [DIGITS*CELL_W-1:0] char_cells,
  output logic [DIGITS-1:0]        blink_bits,
  output logic [SLOT_W-1:0]        glyph_ptr,
  output logic [7:0]               ctrl_word,
  input  logic [SLOT_W+2:0]        pat_raddr,
  output logic [ROW_W-1:0]         pat_rdata,
  output logic [$clog2(DIGITS)-1:0] scan_pos
);
  localparam int DW    = $clog2(DIGITS);
  localparam int PA_W  = SLOT_W + 3;
  localparam int PDEP  = 1 << PA_W;
  localparam int RC_W  = $clog2(READY_CYCLES + 1);

  logic [2:0] wr_sync, ce_sync;
  always_ff @(posedge clk) begin
    wr_sync <= {wr_sync[1:0], wr_n};
    ce_sync <= {ce_sync[1:0], ce_n};
  end

  logic wr_pulse, wr_en;
  assign wr_pulse = wr_sync[1] & ~wr_sync[2] & ~ce_sync[1];

  logic [RC_W-1:0] rdy_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_cnt <= '0;
    else if (rdy_cnt != RC_W'(READY_CYCLES)) rdy_cnt <= rdy_cnt + 1'b1;
  assign ready = (rdy_cnt == RC_W'(READY_CYCLES));
  assign wr_en = wr_pulse & ready;

  logic a4, a3;
  assign a4 = host_addr[4];
  assign a3 = host_addr[3];
  logic sel_blink, sel_ptr, sel_pat, sel_char, sel_ctrl;
  assign sel_blink = ~flash_sel_n;
  assign sel_ptr   = flash_sel_n & ~a4 & ~a3;
  assign sel_pat   = flash_sel_n & ~a4 &  a3;
  assign sel_ctrl  = flash_sel_n &  a4 & ~a3;
  assign sel_char  = flash_sel_n &  a4 &  a3;

  logic [DW-1:0]   idx;
  logic [PA_W-1:0] pat_waddr;
  assign idx       = host_addr[DW-1:0];
  assign pat_waddr = {glyph_ptr, host_addr[2:0]};

  logic [CELL_W-1:0] char_q [DIGITS];
  logic [ROW_W-1:0]  pat_q  [PDEP];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blink_bits <= '0;
      glyph_ptr  <= '0;
      ctrl_word  <= '0;
      scan_pos   <= '0;
      for (int i = 0; i < DIGITS; i++) char_q[i] <= BLANK;
    end else begin
      scan_pos <= scan_pos + 1'b1;
      if (wr_en && sel_blink) blink_bits[idx] <= host_data[0];
      if (wr_en && sel_ptr)   glyph_ptr       <= host_data[SLOT_W-1:0];
      if (wr_en && sel_ctrl)  ctrl_word       <= host_data;
      if (wr_en && sel_char)  char_q[idx]     <= host_data[CELL_W-1:0];
    end

  always_ff @(posedge clk)
    if (wr_en && sel_pat) pat_q[pat_waddr] <= host_data[ROW_W-1:0];

  assign pat_rdata = pat_q[pat_raddr];

  for (genvar g = 0; g < DIGITS; g++) begin : g_cells
    assign char_cells[g*CELL_W +: CELL_W] = char_q[g];
  end

  always_comb begin
    rd_data = '0;
    if (sel_blink)     rd_data[0]          = blink_bits[idx];
    else if (sel_ptr)  rd_data[SLOT_W-1:0] = glyph_ptr;
    else if (sel_pat)  rd_data[ROW_W-1:0]  = pat_q[pat_waddr];
    else if (sel_char) rd_data             = char_q[idx];
    else               rd_data             = ctrl_word;
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_no_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(ctrl_word) && $stable(blink_bits) && $stable(glyph_ptr));
  p_ctrl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_ctrl) |=> ctrl_word == $past(host_data));
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_ptr) |=> glyph_ptr == $past(host_data[SLOT_W-1:0]));
  p_blink_d0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_blink) |=> blink_bits[$past(idx)] == $past(host_data[0]));
  p_scan_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> scan_pos == DW'($past(scan_pos) + 1'b1));
endmodule

// File: tb/sim_disp_host_regs.sv
`timescale 1ns/1ps
module sim_disp_host_regs;
  logic clk = 0, rst_n = 0;
  logic [7:0] host_data = 0;
  logic [4:0] host_addr = 0;
  logic flash_sel_n = 1, ce_n = 1, wr_n = 1;
  logic [7:0] rd_data, ctrl_word, blink_bits;
  logic ready;
  logic [63:0] char_cells;
  logic [3:0] glyph_ptr;
  logic [6:0] pat_raddr = 0;
  logic [4:0] pat_rdata;
  logic [2:0] scan_pos;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  disp_host_regs u0 (.clk, .rst_n, .host_data, .host_addr, .flash_sel_n, .ce_n, .wr_n,
    .rd_data, .ready, .char_cells, .blink_bits, .glyph_ptr, .ctrl_word,
    .pat_raddr, .pat_rdata, .scan_pos);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic fs_n, logic [4:0] a, logic [7:0] d, logic ce = 1'b0);
    @(negedge clk);
    flash_sel_n = fs_n; host_addr = a; host_data = d; ce_n = ce;
    clks(1); wr_n = 0;
    clks(3); wr_n = 1;
    clks(5); ce_n = 1;
  endtask

  task automatic rd_check(string req, logic fs_n, logic [4:0] a, logic [7:0] exp);
    @(negedge clk);
    flash_sel_n = fs_n; host_addr = a;
    #1 chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 0; wr_n = 1; ce_n = 1;
    clks(3);
    chk("R7 cells", char_cells, {8{8'h20}});
    chk("R7 ctrl", ctrl_word, 0);
    chk("R7 blink", blink_bits, 0);
    chk("R7 scan", scan_pos, 0);
    chk("R7 ready", ready, 0);
    rst_n = 1;
    clks(2);
    chk("R8 ready low after 2", ready, 0);
    clks(1);
    chk("R8 ready high after 3", ready, 1);
    clks(4);
    chk("R8 ready stays", ready, 1);
  endtask

  task automatic t_early_write;
    rst_n = 0; flash_sel_n = 1; host_addr = 5'b10000; host_data = 8'hAA;
    ce_n = 0; wr_n = 0;
    clks(4);
    rst_n = 1; wr_n = 1;
    clks(8); ce_n = 1;
    chk("R8 early write ignored", ctrl_word, 0);
    chk("R8 ready", ready, 1);
  endtask

  task automatic t_blink;
    bus_write(0, 5'b11010, 8'hFF);
    bus_write(0, 5'b00101, 8'h01);
    bus_write(0, 5'b01010, 8'hFE);
    chk("R1 blink bits", blink_bits, 8'h20);
    rd_check("R9 blink read", 0, 5'b00101, 8'h01);
    rd_check("R9 blink read zero", 0, 5'b00010, 8'h00);
  endtask

  task automatic t_ptr_pattern;
    bus_write(1, 5'b00000, 8'hF9);
    chk("R2 ptr", glyph_ptr, 4'h9);
    rd_check("R9 ptr read", 1, 5'b00111, 8'h09);
    bus_write(1, 5'b01100, 8'hFF);
    bus_write(1, 5'b01011, 8'h0A);
    pat_raddr = 7'h4C; #1;
    chk("R3 pattern row4", pat_rdata, 5'h1F);
    pat_raddr = 7'h4B; #1;
    chk("R3 pattern row3", pat_rdata, 5'h0A);
    rd_check("R9 pattern read", 1, 5'b01100, 8'h1F);
  endtask

  task automatic t_char_ctrl;
    bus_write(1, 5'b11011, 8'h41);
    bus_write(1, 5'b11110, 8'h85);
    chk("R4 digit3", char_cells[31:24], 8'h41);
    chk("R4 digit6 glyph flag", char_cells[55:48], 8'h85);
    chk("R4 digit0 blank", char_cells[7:0], 8'h20);
    bus_write(1, 5'b10000, 8'h5A);
    chk("R5 ctrl", ctrl_word, 8'h5A);
    rd_check("R9 char read", 1, 5'b11110, 8'h85);
    rd_check("R9 ctrl read", 1, 5'b10101, 8'h5A);
  endtask

  task automatic t_ce_gate;
    bus_write(1, 5'b10000, 8'h33, 1'b1);
    chk("R6 ce high ignored", ctrl_word, 8'h5A);
    bus_write(1, 5'b10000, 8'h77);
    chk("R6 ce low taken", ctrl_word, 8'h77);
  endtask

  task automatic t_scan;
    logic [2:0] s0;
    @(negedge clk); s0 = scan_pos;
    clks(1);
    chk("R10 step", scan_pos, 3'(s0 + 1));
    clks(7);
    chk("R10 wrap", scan_pos, s0);
  endtask

  task automatic t_rereset;
    rst_n = 0; clks(2);
    chk("R7 cells after rereset", char_cells, {8{8'h20}});
    chk("R7 ctrl after rereset", ctrl_word, 0);
    chk("R7 blink after rereset", blink_bits, 0);
    rst_n = 1; clks(4);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_early_write;
        t_blink;
        t_ptr_pattern;
        t_char_ctrl;
        t_ce_gate;
        t_scan;
        t_rereset;
      end
      begin
        clks(20000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule